// File: doc/BRIEF.md
# Message-Signalled Interrupt Vector Table Controller

This block keeps a table of interrupt vectors, each holding a 64-bit message address, a 32-bit message payload and a per-vector mask. It also keeps a bit array that records pending requests and two function-level control bits (enable and mask-all). Device logic raises a request by naming a vector. If that vector is in use and not masked, the block emits one address/data message on a valid/ready output. If the vector is masked, the request is held as a pending bit. When the vector later becomes unmasked, the held request is replayed.

Software reaches the table and the pending array through one 32-bit word-addressed register port. Table entry `v`, word `w` sits at word address `4*v + w`. The pending array sits in the upper half of the address space. The control bits are written through a separate strobe, which stands in for a configuration-space write. Device logic declares which vectors it uses with use and unuse commands that drive a per-vector counter. Requests to a vector whose counter is zero are thrown away.

Top module: `msix_vec_ctrl`

## Requirements
- R1: After reset, every table word reads 0 except each entry's control word (word 3), which reads 1. Every pending-array word reads 0. The enable and mask-all bits read 0, and no message is offered.
- R2: A bus write to word address `4*v+w` (w=0 address bits 31:0, w=1 address bits 63:32, w=2 payload, w=3 control with the vector mask in bit 0) stores the word, and a read at that address returns it.
- R3: `ctl_word` reads back enable in bit 15, mask-all in bit 14, and NVEC-1 in bits 10:0. A control write loads enable and mask-all.
- R4: A vector counts as masked when enable is 0, when mask-all is 1, or when its own mask bit is 1. Turning enable off and then on again replays the requests held while it was off.
- R5: A request to a vector whose use count is zero produces no message and sets no pending bit.
- R6: A request to a used, masked vector `v` sets bit `v mod 32` of pending word `v/32` and emits nothing. This is the same bit as bit `v mod 8` of byte `v/8` in little-endian order. The pending word `k` is at word address `2^TAW + k`, where TAW = clog2(4*NVEC). The array spans NVEC rounded up to 64 bits.
- R7: A request to a used, unmasked vector emits one message carrying that entry's address and payload.
- R8: When a vector with a pending bit goes from masked to unmasked through its own mask bit, the pending bit clears and the vector's message is emitted.
- R9: A control write that releases the function-level mask checks every vector again. All released vectors are then emitted in ascending vector order, one per accepted transfer.
- R10: While `msg_valid` is 1 and `msg_ready` is 0, `msg_valid`, `msg_addr` and `msg_data` hold steady.
- R11: Bus writes into the pending-array address range leave the pending bits unchanged.
- R12: The use count rises on a use command and falls on an unuse command. When the count falls to zero, the vector's pending bit clears. An unuse at a count of zero changes nothing.
- R13: A control write with enable set to 1 drives `intx_deassert` high for exactly the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | TAW+1 | Word address; the top bit selects the pending array |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| ctl_we | input | 1 | Control write strobe |
| ctl_wenable | input | 1 | New enable value |
| ctl_wmaskall | input | 1 | New mask-all value |
| ctl_word | output | 16 | Control readback: enable, mask-all, table size minus one |
| irq_req | input | 1 | Interrupt request strobe |
| irq_vec | input | VW | Requested vector |
| use_cmd | input | 1 | Increment the use count of cmd_vec |
| unuse_cmd | input | 1 | Decrement the use count of cmd_vec |
| cmd_vec | input | VW | Vector addressed by use/unuse |
| msg_valid | output | 1 | Message offered |
| msg_ready | input | 1 | Message accepted |
| msg_addr | output | 64 | Message address |
| msg_data | output | 32 | Message payload |
| intx_deassert | output | 1 | One-cycle pulse that drops the legacy wire interrupt |

## Verification
Each vector gets a distinct address and payload, so every captured message can be traced to its vector. The request is then tried against each masking cause: an unused vector, a vector masked only by its own bit, a function masked by mask-all, and a function disabled. These cases separate "dropped" from "held" from "sent". A vector is held by setting its own bit, and the function is released with many pending vectors at once, so the emitted order shows whether the replay is truly ascending. The output is stalled during this burst to show that a held message does not move. Repeated use/unuse on one vector, with a request between steps, tells apart a counter that clears pending on reaching zero from one that underflows.

// File: rtl/msix_pkg.sv
package msix_pkg;
   localparam int ENT_WORDS    = 4;
   localparam int WRD_ADDR_LO  = 0;
   localparam int WRD_ADDR_HI  = 1;
   localparam int WRD_DATA     = 2;
   localparam int WRD_CTRL     = 3;
   localparam int MAX_VEC      = 2048;

   function automatic int idx_w(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction
endpackage

// File: rtl/msix_table.sv
module msix_table
   import msix_pkg::*;
#(
   parameter int NVEC = 8,
   parameter int TAW  = 5
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  we,
   input  logic [TAW-1:0]        addr,
   input  logic [31:0]           wdata,
   output logic [31:0]           rdata,
   output logic [NVEC-1:0]       vec_mask,
   output logic [NVEC-1:0][63:0] ent_addr,
   output logic [NVEC-1:0][31:0] ent_data
);
   localparam int NW = NVEC * ENT_WORDS;

   logic [31:0] mem [NW];
   logic        in_range;

   assign in_range = (int'(addr) < NW);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < NW; i++)
            mem[i] <= ((i % ENT_WORDS) == WRD_CTRL) ? 32'd1 : 32'd0;
      end else if (we && in_range) begin
         mem[addr] <= wdata;
      end
   end

   assign rdata = in_range ? mem[addr] : 32'd0;

   for (genvar v = 0; v < NVEC; v++) begin : g_ent
      assign vec_mask[v] = mem[v*ENT_WORDS + WRD_CTRL][0];
      assign ent_addr[v] = {mem[v*ENT_WORDS + WRD_ADDR_HI], mem[v*ENT_WORDS + WRD_ADDR_LO]};
      assign ent_data[v] = mem[v*ENT_WORDS + WRD_DATA];
   end
endmodule

// File: rtl/msix_vec_state.sv
module msix_vec_state #(
   parameter int NVEC = 8,
   parameter int VW   = 3,
   parameter int CW   = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NVEC-1:0] masked,
   input  logic            irq_req,
   input  logic [VW-1:0]   irq_vec,
   input  logic            use_cmd,
   input  logic            unuse_cmd,
   input  logic [VW-1:0]   cmd_vec,
   output logic [NVEC-1:0] pend,
   output logic [NVEC-1:0] fire
);
   for (genvar v = 0; v < NVEC; v++) begin : g_vec
      logic [CW-1:0] cnt;
      logic          pq, mq;
      logic          hit, up, dn, used, replay, to_zero;

      assign hit     = irq_req   && (irq_vec == VW'(v));
      assign up      = use_cmd   && (cmd_vec == VW'(v));
      assign dn      = unuse_cmd && (cmd_vec == VW'(v));
      assign used    = |cnt;
      assign replay  = mq && !masked[v] && pq;
      assign to_zero = dn && !up && (cnt == CW'(1));

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            cnt <= '0;
            pq  <= 1'b0;
            mq  <= 1'b1;
         end else begin
            mq <= masked[v];
            if (up && !dn && (cnt != {CW{1'b1}}))
               cnt <= cnt + CW'(1);
            else if (dn && !up && used)
               cnt <= cnt - CW'(1);
            if (replay || to_zero)
               pq <= 1'b0;
            else if (hit && used && masked[v])
               pq <= 1'b1;
         end
      end

      assign pend[v] = pq;
      assign fire[v] = replay || (hit && used && !masked[v]);

      assert_pend_needs_mask_R6: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(pq) |-> $past(masked[v]));
      assert_unused_no_pend_R12: assert property (@(posedge clk) disable iff (!rst_n)
         (cnt == '0) |-> !pq);
      assert_unmask_drains_R8: assert property (@(posedge clk) disable iff (!rst_n)
         (!masked[v] && !mq) |-> !pq);
   end
endmodule

// File: rtl/msix_emit.sv
module msix_emit #(
   parameter int NVEC = 8,
   parameter int VW   = 3
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [NVEC-1:0]       fire,
   input  logic [NVEC-1:0][63:0] ent_addr,
   input  logic [NVEC-1:0][31:0] ent_data,
   input  logic                  msg_ready,
   output logic                  msg_valid,
   output logic [63:0]           msg_addr,
   output logic [31:0]           msg_data
);
   logic [NVEC-1:0] due, clr;
   logic [VW-1:0]   pick;
   logic            any, load;

   always_comb begin
      pick = '0;
      any  = 1'b0;
      for (int i = NVEC-1; i >= 0; i--) begin
         if (due[i]) begin
            pick = VW'(i);
            any  = 1'b1;
         end
      end
   end

   assign load = any && (!msg_valid || msg_ready);
   assign clr  = load ? (NVEC'(1) << pick) : '0;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         due       <= '0;
         msg_valid <= 1'b0;
         msg_addr  <= '0;
         msg_data  <= '0;
      end else begin
         due <= (due & ~clr) | fire;
         if (load) begin
            msg_valid <= 1'b1;
            msg_addr  <= ent_addr[pick];
            msg_data  <= ent_data[pick];
         end else if (msg_ready) begin
            msg_valid <= 1'b0;
         end
      end
   end

   assert_hold_stall_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_addr) && $stable(msg_data)));
endmodule

// File: rtl/msix_vec_ctrl.sv
module msix_vec_ctrl
   import msix_pkg::*;
#(
   parameter int NVEC = 8,
   parameter int CW   = 4,
   localparam int TAW = idx_w(NVEC * ENT_WORDS),
   localparam int AW  = TAW + 1,
   localparam int VW  = idx_w(NVEC)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          bus_we,
   input  logic [AW-1:0] bus_addr,
   input  logic [31:0]   bus_wdata,
   output logic [31:0]   bus_rdata,
   input  logic          ctl_we,
   input  logic          ctl_wenable,
   input  logic          ctl_wmaskall,
   output logic [15:0]   ctl_word,
   input  logic          irq_req,
   input  logic [VW-1:0] irq_vec,
   input  logic          use_cmd,
   input  logic          unuse_cmd,
   input  logic [VW-1:0] cmd_vec,
   output logic          msg_valid,
   input  logic          msg_ready,
   output logic [63:0]   msg_addr,
   output logic [31:0]   msg_data,
   output logic          intx_deassert
);
   localparam int PW = ((NVEC + 63) / 64) * 2;

   if (NVEC < 1 || NVEC > MAX_VEC) begin : g_bad_nvec
      $error("NVEC out of range");
   end
   if (CW < 1) begin : g_bad_cw
      $error("CW must be at least 1");
   end

   logic                  en_q, mall_q, fmask;
   logic [NVEC-1:0]       vec_mask, masked, pend, fire;
   logic [NVEC-1:0][63:0] ent_addr;
   logic [NVEC-1:0][31:0] ent_data;
   logic [31:0]           tbl_rd, pba_rd;
   logic [PW*32-1:0]      pba_pad;
   logic                  sel_pba;

   assign sel_pba = bus_addr[AW-1];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_q          <= 1'b0;
         mall_q        <= 1'b0;
         intx_deassert <= 1'b0;
      end else begin
         intx_deassert <= ctl_we && ctl_wenable;
         if (ctl_we) begin
            en_q   <= ctl_wenable;
            mall_q <= ctl_wmaskall;
         end
      end
   end

   assign fmask    = !en_q || mall_q;
   assign masked   = {NVEC{fmask}} | vec_mask;
   assign ctl_word = {en_q, mall_q, 3'b000, 11'(NVEC - 1)};

   msix_table #(.NVEC(NVEC), .TAW(TAW)) u_table (
      .clk(clk), .rst_n(rst_n),
      .we(bus_we && !sel_pba), .addr(bus_addr[TAW-1:0]), .wdata(bus_wdata),
      .rdata(tbl_rd), .vec_mask(vec_mask), .ent_addr(ent_addr), .ent_data(ent_data)
   );

   msix_vec_state #(.NVEC(NVEC), .VW(VW), .CW(CW)) u_state (
      .clk(clk), .rst_n(rst_n), .masked(masked),
      .irq_req(irq_req), .irq_vec(irq_vec),
      .use_cmd(use_cmd), .unuse_cmd(unuse_cmd), .cmd_vec(cmd_vec),
      .pend(pend), .fire(fire)
   );

   msix_emit #(.NVEC(NVEC), .VW(VW)) u_emit (
      .clk(clk), .rst_n(rst_n), .fire(fire),
      .ent_addr(ent_addr), .ent_data(ent_data),
      .msg_ready(msg_ready), .msg_valid(msg_valid),
      .msg_addr(msg_addr), .msg_data(msg_data)
   );

   assign pba_pad = {{(PW*32-NVEC){1'b0}}, pend};

   always_comb begin
      pba_rd = 32'd0;
      for (int k = 0; k < PW; k++)
         if (int'(bus_addr[TAW-1:0]) == k) pba_rd = pba_pad[k*32 +: 32];
   end

   assign bus_rdata = sel_pba ? pba_rd : tbl_rd;

   assert_intx_when_enabled_R13: assert property (@(posedge clk) disable iff (!rst_n)
      intx_deassert |-> en_q);
endmodule

// File: tb/sim_msix_vec_ctrl.sv
`timescale 1ns/1ps
module sim_msix_vec_ctrl;
   localparam int NV   = 40;
   localparam int TAW  = $clog2(NV * 4);
   localparam int AW   = TAW + 1;
   localparam int VW   = $clog2(NV);
   localparam int PBAB = 1 << TAW;

   logic clk = 1'b0, rst_n = 1'b0;
   logic bus_we = 0; logic [AW-1:0] bus_addr = '0; logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic ctl_we = 0, ctl_wenable = 0, ctl_wmaskall = 0;
   logic [15:0] ctl_word;
   logic irq_req = 0; logic [VW-1:0] irq_vec = '0;
   logic use_cmd = 0, unuse_cmd = 0; logic [VW-1:0] cmd_vec = '0;
   logic msg_valid, msg_ready = 1; logic [63:0] msg_addr; logic [31:0] msg_data;
   logic intx_deassert;

   int nchk = 0, nfail = 0, ncap = 0;
   bit done = 0;
   logic [63:0] cap_a [128];
   logic [31:0] cap_d [128];

   always #2.5 clk = ~clk;

   msix_vec_ctrl #(.NVEC(NV)) u0 (.*);

   always @(negedge clk)
      if (rst_n && msg_valid && msg_ready && ncap < 128) begin
         cap_a[ncap] = msg_addr; cap_d[ncap] = msg_data; ncap++;
      end

   function automatic logic [63:0] eaddr(input int v);
      return {32'h0000_B000 + 32'(v), 32'hA000_0000 | (32'(v) << 4)};
   endfunction
   function automatic logic [31:0] edata(input int v);
      return 32'h0000_D000 + 32'(v);
   endfunction

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      nchk++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask
   task automatic wr(input int a, input logic [31:0] d);
      bus_we = 1; bus_addr = AW'(a); bus_wdata = d; cyc(1); bus_we = 0;
   endtask
   task automatic rd(input int a, output logic [31:0] d);
      bus_addr = AW'(a); @(negedge clk); d = bus_rdata; cyc(1);
   endtask
   task automatic ctl(input logic e, input logic m, output logic ix1, output logic ix2);
      ctl_we = 1; ctl_wenable = e; ctl_wmaskall = m; cyc(1); ctl_we = 0;
      @(negedge clk); ix1 = intx_deassert; cyc(1);
      @(negedge clk); ix2 = intx_deassert; cyc(1);
   endtask
   task automatic irq(input int v);
      irq_req = 1; irq_vec = VW'(v); cyc(1); irq_req = 0;
   endtask
   task automatic usecmd(input int v, input bit up);
      use_cmd = up; unuse_cmd = !up; cmd_vec = VW'(v); cyc(1);
      use_cmd = 0; unuse_cmd = 0;
   endtask
   task automatic pba_chk(input string req, input logic [31:0] e0, input logic [31:0] e1);
      logic [31:0] d;
      rd(PBAB, d); chk(req, 64'(d), 64'(e0));
      rd(PBAB + 1, d); chk(req, 64'(d), 64'(e1));
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         nfail++;
         $display("FAIL watchdog act=timeout exp=finish");
         $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
         $finish;
      end
   end

   initial begin
      logic [31:0] d;
      logic ix1, ix2;
      logic [63:0] held_a;
      int base;
      cyc(4); rst_n = 1; cyc(1);

      // R1: reset state
      for (int v = 0; v < NV; v++)
         for (int w = 0; w < 4; w++) begin
            rd(v*4 + w, d); chk("R1 table", 64'(d), (w == 3) ? 64'd1 : 64'd0);
         end
      pba_chk("R1 pba", 32'd0, 32'd0);
      chk("R1 ctl", 64'(ctl_word), 64'(NV - 1));
      chk("R1 valid", 64'(msg_valid), 64'd0);

      // R2: program and read back every entry, all kept masked
      for (int v = 0; v < NV; v++) begin
         wr(v*4 + 0, eaddr(v)[31:0]); wr(v*4 + 1, eaddr(v)[63:32]);
         wr(v*4 + 2, edata(v));       wr(v*4 + 3, 32'd1);
      end
      for (int v = 0; v < NV; v++) begin
         rd(v*4 + 0, d); chk("R2 lo", 64'(d), 64'(eaddr(v)[31:0]));
         rd(v*4 + 1, d); chk("R2 hi", 64'(d), 64'(eaddr(v)[63:32]));
         rd(v*4 + 2, d); chk("R2 data", 64'(d), 64'(edata(v)));
         rd(v*4 + 3, d); chk("R2 ctrl", 64'(d), 64'd1);
      end

      // R3 / R13: enable function
      ctl(1, 0, ix1, ix2);
      chk("R3 ctl", 64'(ctl_word), 64'(16'h8000 | 16'(NV - 1)));
      chk("R13 pulse", 64'(ix1), 64'd1);
      chk("R13 single", 64'(ix2), 64'd0);

      // R5: unused vector 0 unmasked, request dropped
      wr(3, 32'd0); irq(0); cyc(4);
      chk("R5 no msg", 64'(ncap), 64'd0);
      pba_chk("R5 pba", 32'd0, 32'd0);
      wr(3, 32'd1);

      for (int v = 0; v < NV; v++) usecmd(v, 1);

      // R6: requests on individually masked vectors all become pending
      for (int v = 0; v < NV; v++) irq(v);
      cyc(3);
      pba_chk("R6 pba", 32'hFFFF_FFFF, 32'h0000_00FF);
      chk("R6 no msg", 64'(ncap), 64'd0);

      // R11: pending array writes ignored
      wr(PBAB, 32'd0); wr(PBAB + 1, 32'd0);
      pba_chk("R11 pba", 32'hFFFF_FFFF, 32'h0000_00FF);

      // R8: unmask vector 5 alone
      wr(5*4 + 3, 32'd0); cyc(5);
      chk("R8 count", 64'(ncap), 64'd1);
      chk("R8 addr", cap_a[0], eaddr(5));
      chk("R8 data", 64'(cap_d[0]), 64'(edata(5)));
      pba_chk("R8 pba", 32'hFFFF_FFDF, 32'h0000_00FF);

      // R9 / R10: mask-all, unmask all bits, then release at once with stall
      ctl(1, 1, ix1, ix2);
      chk("R3 maskall", 64'(ctl_word), 64'(16'hC000 | 16'(NV - 1)));
      for (int v = 0; v < NV; v++) wr(v*4 + 3, 32'd0);
      cyc(4);
      chk("R4 maskall holds", 64'(ncap), 64'd1);
      pba_chk("R4 pba", 32'hFFFF_FFDF, 32'h0000_00FF);
      msg_ready = 0;
      ctl(1, 0, ix1, ix2);
      cyc(3);
      @(negedge clk);
      chk("R10 valid", 64'(msg_valid), 64'd1);
      held_a = msg_addr;
      chk("R9 first", held_a, eaddr(0));
      cyc(5);
      @(negedge clk);
      chk("R10 stable valid", 64'(msg_valid), 64'd1);
      chk("R10 stable addr", msg_addr, held_a);
      chk("R10 stable data", 64'(msg_data), 64'(edata(0)));
      cyc(1);
      msg_ready = 1; cyc(60);
      chk("R9 count", 64'(ncap), 64'(NV));
      for (int i = 1; i < NV; i++) begin
         chk("R9 order addr", cap_a[i], eaddr((i - 1 < 5) ? i - 1 : i));
         chk("R9 order data", 64'(cap_d[i]), 64'(edata((i - 1 < 5) ? i - 1 : i)));
      end
      pba_chk("R9 pba", 32'd0, 32'd0);

      // R4: disabled function holds, re-enable replays
      ctl(0, 0, ix1, ix2);
      chk("R13 no pulse", 64'(ix1), 64'd0);
      base = ncap;
      irq(3); cyc(3);
      chk("R4 off holds", 64'(ncap), 64'(base));
      pba_chk("R4 off pba", 32'h0000_0008, 32'd0);
      ctl(1, 0, ix1, ix2); cyc(4);
      chk("R4 replay count", 64'(ncap), 64'(base + 1));
      chk("R4 replay data", 64'(cap_d[base]), 64'(edata(3)));
      pba_chk("R4 cleared", 32'd0, 32'd0);

      // R7: direct delivery
      base = ncap;
      irq(7); cyc(4);
      chk("R7 count", 64'(ncap), 64'(base + 1));
      chk("R7 addr", cap_a[base], eaddr(7));
      chk("R7 data", 64'(cap_d[base]), 64'(edata(7)));

      // R12: use counting on vector 2
      usecmd(2, 1);
      wr(2*4 + 3, 32'd1);
      irq(2); cyc(2);
      pba_chk("R12 pend", 32'h0000_0004, 32'd0);
      usecmd(2, 0); cyc(1);
      pba_chk("R12 count 1 keeps", 32'h0000_0004, 32'd0);
      usecmd(2, 0); cyc(1);
      pba_chk("R12 zero clears", 32'd0, 32'd0);
      usecmd(2, 0);
      base = ncap;
      irq(2); cyc(2);
      pba_chk("R12 dropped", 32'd0, 32'd0);
      usecmd(2, 1);
      irq(2); cyc(2);
      pba_chk("R12 no underflow", 32'h0000_0004, 32'd0);
      wr(2*4 + 3, 32'd0); cyc(4);
      chk("R12 count", 64'(ncap), 64'(base + 1));
      chk("R12 data", 64'(cap_d[base]), 64'(edata(2)));

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
   end
endmodule